// File: doc/BRIEF.md
# Message-Signalled Interrupt Landing Array

This block is the landing point for message-signalled interrupts. An endpoint raises an interrupt by writing a small data word to an address in the block's 16 MiB window. The address picks one of sixteen groups and one of eight 16-bit index registers in that group. The low four bits of the data pick the bit to set in that register. With 16 groups, 8 registers per group and 16 bits per register, there are 2048 distinct vectors.

Software handles a group's interrupt in two steps. It first reads that group's summary word, in which each bit flags an index register with something pending. It then reads the flagged index registers. A read returns the register's contents and empties the register in the same cycle. Each group drives a level-sensitive interrupt line. The line is registered and stays high while any register in the group holds a bit.

Writes take a single-cycle valid pulse. A read is accepted with a single-cycle valid pulse, and its data is returned one cycle later together with an acknowledge.

Top module: `msi_term_array`

## Requirements
- R1: A write to byte offset (g<<19)+(i<<16), with g from 0 to 15 and i from 0 to 7, sets bit wr_data[3:0] of index register i of group g. The other bits of that register keep their values, so repeated writes accumulate bits.
- R2: A read pulse at an index register offset returns, on the next cycle, the register's contents zero-extended on rd_data with rd_ack high. The register is zero afterwards.
- R3: A read of offset 0x800000+(g<<16) returns group g's summary word. Bit x (x from 0 to 7) of that word is 1 exactly when index register x of group g is non-zero. Bits 31:8 of the word are 0.
- R4: irq[g] is a registered OR of group g's pending state. After a write at clock edge k, irq[g] is high following edge k+1. After the read that empties the group's last register at edge k, irq[g] is low following edge k+1.
- R5: When a write and a read hit the same index register in the same cycle, the read returns only the earlier contents and the newly written bit stays set afterwards.
- R6: Writes to summary offsets, and writes to offsets that decode to no register, change no state. An offset decodes to no register when its bits 15:0 are non-zero or when it is 0x900000 or above.
- R7: Reads of offsets that decode to no register return zero and do not clear any index register.
- R8: Vector v is delivered by a write to group v%16 and index v/256 with data (v/16)%16. For example, vector 1234 is delivered to offset 0x140000 with data 13.
- R9: Synchronous active-high reset empties every register and drives irq and rd_ack low.
- R10: Bits 31:4 of wr_data have no effect on which bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write strobe, one cycle per message |
| wr_addr | input | 24 | Write byte offset within the window |
| wr_data | input | 32 | Write data; bits 3:0 give the bit number |
| rd_valid | input | 1 | Read strobe |
| rd_addr | input | 24 | Read byte offset |
| rd_data | output | 32 | Read data, valid when rd_ack is high |
| rd_ack | output | 1 | High for one cycle, one cycle after rd_valid |
| irq | output | 16 | One level-sensitive interrupt per group |

## Verification
The tests use a single vector and check its irq edge timing, to tell a combinational interrupt output from a registered one. They use several bits in one register, including the lowest and highest bit and data carrying high junk bits, to show that the block ORs bits rather than overwriting and that it decodes only four data bits. A vector taken from the numbering formula, and interrupts on several groups at once, check the address slicing across group and index. A write and a read on the same register in the same cycle separate read-then-clear ordering from a clear that drops the new bit. Writes and reads aimed at summary offsets and undecoded offsets show that nothing changes and that nothing is cleared by accident.

// File: rtl/msi_term_pkg.sv
package msi_term_pkg;
  typedef enum logic [1:0] {
    SEL_NONE    = 2'd0,
    SEL_INDEX   = 2'd1,
    SEL_SUMMARY = 2'd2
  } sel_kind_e;
endpackage

// File: rtl/msi_addr_decode.sv
module msi_addr_decode
  import msi_term_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int GRP_W  = 4,
  parameter int IDX_W  = 3,
  parameter int OFS_W  = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_kind_e         kind,
  output logic [GRP_W-1:0]  grp,
  output logic [IDX_W-1:0]  idx
);
  // index region: top bit clear, group above index, each register on a 64 KiB stride
  // summary region: top bit set, group in the slot just above the stride
  logic low_clear;
  assign low_clear = (addr[OFS_W-1:0] == '0);

  always_comb begin
    kind = SEL_NONE;
    grp  = '0;
    idx  = '0;
    if (low_clear) begin
      if (!addr[ADDR_W-1]) begin
        kind = SEL_INDEX;
        grp  = addr[OFS_W+IDX_W +: GRP_W];
        idx  = addr[OFS_W +: IDX_W];
      end else if (addr[OFS_W+GRP_W +: IDX_W] == '0) begin
        kind = SEL_SUMMARY;
        grp  = addr[OFS_W +: GRP_W];
      end
    end
  end
endmodule

// File: rtl/msi_group_bank.sv
module msi_group_bank #(
  parameter int NIDX  = 8,
  parameter int NBIT  = 16,
  parameter int IDX_W = 3,
  parameter int BIT_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 set_en,
  input  logic [IDX_W-1:0]     set_idx,
  input  logic [BIT_W-1:0]     set_bit,
  input  logic                 clr_en,
  input  logic [IDX_W-1:0]     clr_idx,
  output logic [NIDX*NBIT-1:0] words_flat,
  output logic [NIDX-1:0]      pending,
  output logic                 irq_q
);
  logic [NBIT-1:0] set_mask;
  assign set_mask = NBIT'(1) << set_bit;

  for (genvar i = 0; i < NIDX; i++) begin : g_word
    logic [NBIT-1:0] word_q, word_d;
    always_comb begin
      word_d = word_q;
      if (clr_en && clr_idx == IDX_W'(i)) word_d = '0;
      // a set in the clearing cycle survives the clear
      if (set_en && set_idx == IDX_W'(i)) word_d = word_d | set_mask;
    end
    always_ff @(posedge clk) begin
      if (rst) word_q <= '0;
      else     word_q <= word_d;
    end
    assign words_flat[i*NBIT +: NBIT] = word_q;
    assign pending[i] = |word_q;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |pending;
  end
endmodule

// File: rtl/msi_term_array.sv
module msi_term_array
  import msi_term_pkg::*;
#(
  parameter int NGRP   = 16,
  parameter int NIDX   = 8,
  parameter int NBIT   = 16,
  parameter int OFS_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_valid,
  input  logic [OFS_W+$clog2(NGRP)+$clog2(NIDX):0] wr_addr,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic                           rd_valid,
  input  logic [OFS_W+$clog2(NGRP)+$clog2(NIDX):0] rd_addr,
  output logic [DATA_W-1:0]              rd_data,
  output logic                           rd_ack,
  output logic [NGRP-1:0]                irq
);
  localparam int GRP_W  = $clog2(NGRP);
  localparam int IDX_W  = $clog2(NIDX);
  localparam int BIT_W  = $clog2(NBIT);
  localparam int ADDR_W = OFS_W + GRP_W + IDX_W + 1;

  sel_kind_e        wr_kind, rd_kind;
  logic [GRP_W-1:0] wr_grp, rd_grp;
  logic [IDX_W-1:0] wr_idx, rd_idx;

  msi_addr_decode #(.ADDR_W(ADDR_W), .GRP_W(GRP_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_wdec (
    .addr(wr_addr), .kind(wr_kind), .grp(wr_grp), .idx(wr_idx));
  msi_addr_decode #(.ADDR_W(ADDR_W), .GRP_W(GRP_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_rdec (
    .addr(rd_addr), .kind(rd_kind), .grp(rd_grp), .idx(rd_idx));

  logic                 wr_hit, rd_hit;
  logic [NIDX*NBIT-1:0] words [NGRP];
  logic [NIDX-1:0]      pend  [NGRP];

  assign wr_hit = wr_valid && (wr_kind == SEL_INDEX);
  assign rd_hit = rd_valid && (rd_kind == SEL_INDEX);

  for (genvar g = 0; g < NGRP; g++) begin : g_bank
    msi_group_bank #(.NIDX(NIDX), .NBIT(NBIT), .IDX_W(IDX_W), .BIT_W(BIT_W)) u_bank (
      .clk       (clk),
      .rst       (rst),
      .set_en    (wr_hit && wr_grp == GRP_W'(g)),
      .set_idx   (wr_idx),
      .set_bit   (wr_data[BIT_W-1:0]),
      .clr_en    (rd_hit && rd_grp == GRP_W'(g)),
      .clr_idx   (rd_idx),
      .words_flat(words[g]),
      .pending   (pend[g]),
      .irq_q     (irq[g])
    );
  end

  logic [DATA_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    case (rd_kind)
      SEL_INDEX:   rd_next = DATA_W'(words[rd_grp][rd_idx*NBIT +: NBIT]);
      SEL_SUMMARY: rd_next = DATA_W'(pend[rd_grp]);
      default:     rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      rd_ack  <= 1'b0;
    end else begin
      rd_ack <= rd_valid;
      if (rd_valid) rd_data <= rd_next;
    end
  end
endmodule

// File: rtl/msi_term_array_checker.sv
module msi_term_array_checker #(
  parameter int NGRP   = 16,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int NIDX   = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_ack,
  input logic [NGRP-1:0]   irq
);
  localparam int GRP_W = $clog2(NGRP);
  localparam int IDX_W = $clog2(NIDX);
  localparam int OFS_W = ADDR_W - 1 - GRP_W - IDX_W;

  logic wr_is_index, rd_is_index, rd_is_summary, rd_is_none;
  assign wr_is_index   = !wr_addr[ADDR_W-1] && wr_addr[OFS_W-1:0] == '0;
  assign rd_is_index   = !rd_addr[ADDR_W-1] && rd_addr[OFS_W-1:0] == '0;
  assign rd_is_summary = rd_addr[ADDR_W-1] && rd_addr[OFS_W-1:0] == '0
                         && rd_addr[ADDR_W-2:OFS_W+GRP_W] == '0;
  assign rd_is_none    = !rd_is_index && !rd_is_summary;

  // R4: an accepted write shows on its group's line two edges later
  p_irq_after_write_r4: assert property (@(posedge clk) disable iff (rst)
    $past(wr_valid && wr_is_index, 2) |-> irq[$past(wr_addr[ADDR_W-2 -: GRP_W], 2)]);

  // R7: undecoded reads come back as zero
  p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (rst)
    $past(rd_valid && rd_is_none) |-> (rd_ack && rd_data == '0));

  // R3: summary word uses only the low index-count bits
  p_summary_width_r3: assert property (@(posedge clk) disable iff (rst)
    $past(rd_valid && rd_is_summary) |-> (rd_data[DATA_W-1:NIDX] == '0));

  // R2: back-to-back reads of one register with no writes return zero the second time
  p_read_clears_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_valid && rd_is_index && !wr_valid) && rd_valid && rd_is_index
     && rd_addr == $past(rd_addr) && !wr_valid) |=> (rd_data == '0));

  // R9: nothing pending right after reset
  p_quiet_after_reset_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq == '0 && !rd_ack));
endmodule

bind msi_term_array msi_term_array_checker #(
  .NGRP(NGRP), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NIDX(NIDX)
) u_chk (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data),
  .rd_ack(rd_ack), .irq(irq)
);

// File: tb/msi_term_array_test.sv
module msi_term_array_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0;
  logic [23:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_valid = 1'b0;
  logic [23:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic        rd_ack;
  logic [15:0] irq;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_term_array uut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data), .rd_ack(rd_ack), .irq(irq));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] idx_ofs(input int g, input int i);
    return 24'((g << 19) + (i << 16));
  endfunction

  function automatic logic [23:0] sum_ofs(input int g);
    return 24'(32'h800000 + (g << 16));
  endfunction

  task automatic do_write(input logic [23:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic do_read(input logic [23:0] a, output logic [31:0] d, output logic ack);
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_valid = 1'b0;
    d = rd_data; ack = rd_ack;
  endtask

  task automatic t_reset();
    logic [31:0] d; logic a;
    check(irq == '0, "R9 irq after reset", 32'(irq), 0);
    check(rd_ack == 1'b0, "R9 rd_ack after reset", 32'(rd_ack), 0);
    for (int g = 0; g < 16; g += 5) begin
      do_read(sum_ofs(g), d, a);
      check(d == 0, "R9 summary empty after reset", d, 0);
    end
  endtask

  task automatic t_single();
    logic [31:0] d; logic a;
    do_write(idx_ofs(3, 2), 32'd5);
    check(irq[3] == 1'b0, "R4 irq not before second edge", 32'(irq), 0);
    @(negedge clk);
    check(irq == 16'h0008, "R4 irq raised", 32'(irq), 32'h8);
    do_read(sum_ofs(3), d, a);
    check(d == 32'h4, "R3 summary bit 2", d, 32'h4);
    do_read(idx_ofs(3, 2), d, a);
    check(a == 1'b1, "R2 rd_ack", 32'(a), 1);
    check(d == 32'h20, "R1 bit 5 set", d, 32'h20);
    check(irq[3] == 1'b1, "R4 irq still high right after clear", 32'(irq), 32'h8);
    @(negedge clk);
    check(irq == '0, "R4 irq low one cycle after clear", 32'(irq), 0);
    do_read(idx_ofs(3, 2), d, a);
    check(d == 0, "R2 register cleared by read", d, 0);
  endtask

  task automatic t_accumulate();
    logic [31:0] d; logic a;
    do_write(idx_ofs(15, 7), 32'd0);
    do_write(idx_ofs(15, 7), 32'd15);
    do_write(idx_ofs(15, 7), 32'h1F3);  // only low nibble (3) counts
    do_read(sum_ofs(15), d, a);
    check(d == 32'h80, "R3 summary bit 7 group 15", d, 32'h80);
    do_read(idx_ofs(15, 7), d, a);
    check(d == 32'h8009, "R1 R10 bits accumulate, high data ignored", d, 32'h8009);
  endtask

  task automatic t_vector();
    logic [31:0] d; logic a;
    int v = 1234;
    do_write(idx_ofs(v % 16, v / 256), 32'((v / 16) % 16));
    check(idx_ofs(v % 16, v / 256) == 24'h140000, "R8 offset for vector 1234", 32'(idx_ofs(2, 4)), 32'h140000);
    @(negedge clk);
    check(irq == 16'h0004, "R8 irq on group 2", 32'(irq), 32'h4);
    do_read(sum_ofs(2), d, a);
    check(d == 32'h10, "R8 summary index 4", d, 32'h10);
    do_read(24'h140000, d, a);
    check(d == 32'h2000, "R8 bit 13", d, 32'h2000);
  endtask

  task automatic t_collide();
    logic [31:0] d; logic a;
    do_write(idx_ofs(0, 0), 32'd1);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = idx_ofs(0, 0); wr_data = 32'd4;
    rd_valid = 1'b1; rd_addr = idx_ofs(0, 0);
    @(negedge clk);
    wr_valid = 1'b0; rd_valid = 1'b0;
    check(rd_data == 32'h2, "R5 read returns earlier contents", rd_data, 32'h2);
    do_read(idx_ofs(0, 0), d, a);
    check(d == 32'h10, "R5 new bit survives clear", d, 32'h10);
  endtask

  task automatic t_ignored();
    logic [31:0] d; logic a;
    do_write(sum_ofs(0), 32'd3);
    do_write(24'h000004, 32'd2);
    do_write(24'h900000, 32'd1);
    do_write(24'h010100, 32'd6);
    @(negedge clk);
    check(irq == '0, "R6 ignored writes raise no irq", 32'(irq), 0);
    do_read(sum_ofs(0), d, a);
    check(d == 0, "R6 summary unchanged", d, 0);
    do_read(idx_ofs(0, 1), d, a);
    check(d == 0, "R6 index 1 untouched", d, 0);
  endtask

  task automatic t_unmapped_read();
    logic [31:0] d; logic a;
    do_write(idx_ofs(0, 0), 32'd7);
    do_read(24'h000010, d, a);
    check(d == 0 && a, "R7 unmapped read returns zero", d, 0);
    do_read(24'hA00000, d, a);
    check(d == 0, "R7 high unmapped read", d, 0);
    do_read(idx_ofs(0, 0), d, a);
    check(d == 32'h80, "R7 unmapped read cleared nothing", d, 32'h80);
  endtask

  task automatic t_multi_group();
    logic [31:0] d; logic a;
    do_write(idx_ofs(1, 0), 32'd0);
    do_write(idx_ofs(14, 5), 32'd9);
    @(negedge clk);
    check(irq == 16'h4002, "R4 two groups pending", 32'(irq), 32'h4002);
    do_read(idx_ofs(1, 0), d, a);
    @(negedge clk);
    check(irq == 16'h4000, "R4 group 1 drops, group 14 stays", 32'(irq), 32'h4000);
    do_read(idx_ofs(14, 5), d, a);
    check(d == 32'h200, "R1 group 14 index 5 bit 9", d, 32'h200);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single();
    t_accumulate();
    t_vector();
    t_collide();
    t_ignored();
    t_unmapped_read();
    t_multi_group();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule